// File: doc/BRIEF.md
# Transaction ID Filter for Memory Port Event Counting

The block sits beside the read-address and write-address channels of a bus port into a DRAM controller. It counts only the transactions whose ID matches a programmed value under a programmed mask. Each accepted address handshake is compared against one shared filter setting. A matching read raises the filtered-read event strobe, and a matching write raises the filtered-write event strobe. Both strobes go to a separate bank of performance counters.

Every strobe comes with an increment value. In count mode the increment is one transaction. In byte mode it is the number of bytes the burst moves. The block also keeps a running byte or transaction total for each direction. A clear input zeroes these totals.

The filter register is 32 bits wide. The ID sits in the low half. The high half holds the compare mask in inverted form, so an all-ones upper half compares no bits at all.

Top module: `axid_filter`

## Requirements
- R1: After reset the filter register is zero, both strobes, both increments and both totals are zero, and the effective mask is all ones, so only ID 0 matches.
- R2: A write with `cfgWe` stores `cfgWdata[15:0]` as the filter ID and `cfgWdata[31:16]` as the inverted mask (effective mask = ~`cfgWdata[31:16]`). A handshake in the same cycle as the write is still judged against the previous setting.
- R3: A strobe is raised only for a cycle in which the channel's valid and ready are both high. It is a one-cycle pulse, visible right after the clock edge that accepts the handshake.
- R4: A transaction matches when ((ID xor filterId) and effectiveMask) equals zero. With an effective mask of zero (upper half written as 0xFFFF), every ID matches.
- R5: The read and write channels use the same filter setting and are judged independently, so both strobes may pulse in the same cycle.
- R6: With `byteMode` low, the increment of a strobed transaction is 1. The increment is 0 in any cycle without a strobe.
- R7: With `byteMode` high, the increment is (LEN+1) shifted left by SIZE, with LEN as the 8-bit beat count minus one and SIZE as the 3-bit log2 of bytes per beat.
- R8: Each total adds its channel's increment on every strobe and wraps modulo 2^ACC_W. Without a strobe it holds its value.
- R9: `accClr` zeroes both totals at the next edge. If a strobe lands in the same cycle, the total becomes that strobe's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Filter register write enable |
| cfgWdata | input | 32 | Filter value: ID low half, inverted mask high half |
| byteMode | input | 1 | 1 = increments in bytes, 0 = in transactions |
| accClr | input | 1 | Clear both running totals |
| arValid | input | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| arId | input | 16 | Read transaction ID |
| arLen | input | 8 | Read burst length minus one |
| arSize | input | 3 | Read log2 bytes per beat |
| awValid | input | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| awId | input | 16 | Write transaction ID |
| awLen | input | 8 | Write burst length minus one |
| awSize | input | 3 | Write log2 bytes per beat |
| rdHit | output | 1 | Filtered-read event strobe |
| wrHit | output | 1 | Filtered-write event strobe |
| rdInc | output | 16 | Read increment for this strobe |
| wrInc | output | 16 | Write increment for this strobe |
| rdTotal | output | 32 | Running read total |
| wrTotal | output | 32 | Running write total |

## Verification
Two cases are hard to reach from the ports.

The first is a filter write that coincides with an address handshake. The stimulus first programs one ID. It then sends a handshake with that ID in the same cycle that a second ID is written, and checks that the old setting decides the match. It finishes by checking that the new setting applies from the next cycle.

The second is total wraparound. The bench builds a small total width and then sends maximum-size bursts in byte mode until the sum wraps back to its start. It also sends a clear in the same cycle as a strobe.

// File: rtl/axf_pkg.sv
package axf_pkg;
  localparam int NCH = 2;   // channel 0 = read, channel 1 = write
  typedef struct packed {
    logic rdHit;
    logic wrHit;
  } hitStrb_t;
endpackage

// File: rtl/axf_ctrl.sv
module axf_ctrl #(
  parameter int ID_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [2*ID_W-1:0]        cfgWdata,
  input  logic [axf_pkg::NCH-1:0]  chValid,
  input  logic [axf_pkg::NCH-1:0]  chReady,
  input  logic [ID_W-1:0]          chId [axf_pkg::NCH],
  output axf_pkg::hitStrb_t        strb
);
  logic [2*ID_W-1:0] filtReg;
  logic [ID_W-1:0]   filtId;
  logic [ID_W-1:0]   effMask;
  logic [axf_pkg::NCH-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rstN)      filtReg <= '0;
    else if (cfgWe) filtReg <= cfgWdata;
  end

  assign filtId  = filtReg[ID_W-1:0];
  assign effMask = ~filtReg[2*ID_W-1:ID_W];

  for (genvar ch = 0; ch < axf_pkg::NCH; ch++) begin : g_match
    assign hit[ch] = chValid[ch] && chReady[ch] &&
                     (((chId[ch] ^ filtId) & effMask) == '0);
  end

  assign strb.rdHit = hit[0];
  assign strb.wrHit = hit[1];
endmodule

// File: rtl/axf_datapath.sv
module axf_datapath #(
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int BYTE_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  axf_pkg::hitStrb_t       strb,
  input  logic                    byteMode,
  input  logic                    accClr,
  input  logic [LEN_W-1:0]        chLen  [axf_pkg::NCH],
  input  logic [SIZE_W-1:0]       chSize [axf_pkg::NCH],
  output logic [axf_pkg::NCH-1:0] hitQ,
  output logic [BYTE_W-1:0]       incQ   [axf_pkg::NCH],
  output logic [ACC_W-1:0]        totQ   [axf_pkg::NCH]
);
  logic [axf_pkg::NCH-1:0] hitIn;
  assign hitIn = {strb.wrHit, strb.rdHit};

  for (genvar ch = 0; ch < axf_pkg::NCH; ch++) begin : g_chan
    logic [BYTE_W-1:0] beats;
    logic [BYTE_W-1:0] incNext;
    logic [ACC_W-1:0]  addVal;

    assign beats   = BYTE_W'(chLen[ch]) + BYTE_W'(1);
    assign incNext = hitIn[ch] ? (byteMode ? (beats << chSize[ch]) : BYTE_W'(1))
                               : '0;
    assign addVal  = ACC_W'(incNext);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hitQ[ch] <= 1'b0;
        incQ[ch] <= '0;
        totQ[ch] <= '0;
      end else begin
        hitQ[ch] <= hitIn[ch];
        incQ[ch] <= incNext;
        totQ[ch] <= accClr ? addVal : totQ[ch] + addVal;
      end
    end

    // R6: count mode gives a unit increment
    a_r6_unit_inc: assert property (@(posedge clk) disable iff (!rstN)
      (hitIn[ch] && !byteMode) |=> (hitQ[ch] && incQ[ch] == BYTE_W'(1)));
    // R8: total holds when nothing is strobed
    a_r8_total_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!accClr && !hitIn[ch]) |=> $stable(totQ[ch]));
    // R9: a clear with no strobe empties the total
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
      (accClr && !hitIn[ch]) |=> (totQ[ch] == '0));
  end
endmodule

// File: rtl/axid_filter.sv
module axid_filter #(
  parameter int ID_W   = 16,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int ACC_W  = 32,
  localparam int BYTE_W = LEN_W + (1 << SIZE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2*ID_W-1:0] cfgWdata,
  input  logic              byteMode,
  input  logic              accClr,
  input  logic              arValid,
  input  logic              arReady,
  input  logic [ID_W-1:0]   arId,
  input  logic [LEN_W-1:0]  arLen,
  input  logic [SIZE_W-1:0] arSize,
  input  logic              awValid,
  input  logic              awReady,
  input  logic [ID_W-1:0]   awId,
  input  logic [LEN_W-1:0]  awLen,
  input  logic [SIZE_W-1:0] awSize,
  output logic              rdHit,
  output logic              wrHit,
  output logic [BYTE_W-1:0] rdInc,
  output logic [BYTE_W-1:0] wrInc,
  output logic [ACC_W-1:0]  rdTotal,
  output logic [ACC_W-1:0]  wrTotal
);
  axf_pkg::hitStrb_t strb;
  logic [ID_W-1:0]   chId   [axf_pkg::NCH];
  logic [LEN_W-1:0]  chLen  [axf_pkg::NCH];
  logic [SIZE_W-1:0] chSize [axf_pkg::NCH];
  logic [BYTE_W-1:0] incQ   [axf_pkg::NCH];
  logic [ACC_W-1:0]  totQ   [axf_pkg::NCH];
  logic [axf_pkg::NCH-1:0] hitQ;

  assign chId[0]   = arId;   assign chId[1]   = awId;
  assign chLen[0]  = arLen;  assign chLen[1]  = awLen;
  assign chSize[0] = arSize; assign chSize[1] = awSize;

  axf_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .chValid({awValid, arValid}), .chReady({awReady, arReady}),
    .chId(chId), .strb(strb)
  );

  axf_datapath #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteMode(byteMode), .accClr(accClr),
    .chLen(chLen), .chSize(chSize), .hitQ(hitQ), .incQ(incQ), .totQ(totQ)
  );

  assign rdHit   = hitQ[0];
  assign wrHit   = hitQ[1];
  assign rdInc   = incQ[0];
  assign wrInc   = incQ[1];
  assign rdTotal = totQ[0];
  assign wrTotal = totQ[1];

  // R3: no read strobe without an accepted read handshake
  a_r3_rd_needs_handshake: assert property (@(posedge clk) disable iff (!rstN)
    !(arValid && arReady) |=> !rdHit);
  // R3: no write strobe without an accepted write handshake
  a_r3_wr_needs_handshake: assert property (@(posedge clk) disable iff (!rstN)
    !(awValid && awReady) |=> !wrHit);
  // R5: equal IDs accepted together on both channels give equal verdicts
  a_r5_shared_filter: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && arReady && awValid && awReady && arId == awId && !cfgWe) |=> (rdHit == wrHit));
endmodule

// File: tb/sim_axid_filter.sv
module sim_axid_filter;
  localparam int ACC_W = 16;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cfgWe, byteMode, accClr;
  logic [31:0] cfgWdata;
  logic arValid, arReady, awValid, awReady;
  logic [15:0] arId, awId;
  logic [7:0] arLen, awLen;
  logic [2:0] arSize, awSize;
  logic rdHit, wrHit;
  logic [15:0] rdInc, wrInc;
  logic [ACC_W-1:0] rdTotal, wrTotal;

  axid_filter #(.ACC_W(ACC_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .byteMode(byteMode),
    .accClr(accClr), .arValid(arValid), .arReady(arReady), .arId(arId), .arLen(arLen),
    .arSize(arSize), .awValid(awValid), .awReady(awReady), .awId(awId), .awLen(awLen),
    .awSize(awSize), .rdHit(rdHit), .wrHit(wrHit), .rdInc(rdInc), .wrInc(wrInc),
    .rdTotal(rdTotal), .wrTotal(wrTotal)
  );

  typedef struct packed {
    logic [31:0] filt;
    logic arV; logic arR; logic [15:0] aId;
    logic awV; logic awR; logic [15:0] wId;
    logic [7:0] len; logic [2:0] size; logic mode;
    logic eRd; logic eWr; logic [15:0] eRdInc; logic [15:0] eWrInc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0012, 1'b1, 1'b1, 16'h0012, 1'b1, 1'b1, 16'h0013, 8'd3, 3'd2, 1'b0, 1'b1, 1'b0, 16'd1, 16'd0},
    '{32'h0000_0012, 1'b1, 1'b1, 16'h0012, 1'b1, 1'b1, 16'h0013, 8'd3, 3'd2, 1'b1, 1'b1, 1'b0, 16'd16, 16'd0},
    '{32'hFF0F_0030, 1'b1, 1'b1, 16'hAB3C, 1'b1, 1'b1, 16'h0040, 8'd0, 3'd0, 1'b1, 1'b1, 1'b0, 16'd1, 16'd0},
    '{32'hFFFF_0000, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, 16'h1234, 8'd255, 3'd7, 1'b1, 1'b1, 1'b1, 16'h8000, 16'h8000},
    '{32'hFFFF_0000, 1'b1, 1'b0, 16'h0001, 1'b0, 1'b1, 16'h0002, 8'd1, 3'd1, 1'b1, 1'b0, 1'b0, 16'd0, 16'd0},
    '{32'h0000_5555, 1'b1, 1'b1, 16'h5555, 1'b1, 1'b1, 16'h5555, 8'd7, 3'd3, 1'b0, 1'b1, 1'b1, 16'd1, 16'd1}
  };

  int nTests = 0, nFail = 0;
  logic [ACC_W-1:0] mRd = '0, mWr = '0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cfgWe = 0; arValid = 0; arReady = 0; awValid = 0; awReady = 0; accClr = 0;
  endtask

  task automatic writeCfg(input logic [31:0] v);
    cfgWe = 1; cfgWdata = v;
    @(negedge clk);
    idle();
  endtask

  task automatic step(input logic we, input logic [31:0] cfg,
                      input logic aV, input logic aR, input logic [15:0] aI,
                      input logic wV, input logic wR, input logic [15:0] wI,
                      input logic [7:0] ln, input logic [2:0] sz, input logic md,
                      input logic clr);
    cfgWe = we; cfgWdata = cfg;
    arValid = aV; arReady = aR; arId = aI; arLen = ln; arSize = sz;
    awValid = wV; awReady = wR; awId = wI; awLen = ln; awSize = sz;
    byteMode = md; accClr = clr;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 0; idle(); byteMode = 0; cfgWdata = '0;
    arId = '0; awId = '0; arLen = '0; awLen = '0; arSize = '0; awSize = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdHit", rdHit, 0);
    check("R1 wrHit", wrHit, 0);
    check("R1 rdTotal", rdTotal, 0);
    check("R1 wrTotal", wrTotal, 0);
    // R1 default filter matches only ID 0
    step(0, 0, 1, 1, 16'h0000, 1, 1, 16'h0005, 8'd0, 3'd0, 0, 0);
    check("R1 id0 match", rdHit, 1);
    check("R1 id5 no match", wrHit, 0);
    mRd = mRd + 1;
    check("R8 rdTotal", rdTotal, mRd);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      writeCfg(VECS[i].filt);
      step(0, 0, VECS[i].arV, VECS[i].arR, VECS[i].aId, VECS[i].awV, VECS[i].awR,
           VECS[i].wId, VECS[i].len, VECS[i].size, VECS[i].mode, 0);
      if (VECS[i].eRd) mRd = mRd + ACC_W'(VECS[i].eRdInc);
      if (VECS[i].eWr) mWr = mWr + ACC_W'(VECS[i].eWrInc);
      check($sformatf("R3 R4 R5 rdHit v%0d", i), rdHit, VECS[i].eRd);
      check($sformatf("R3 R4 R5 wrHit v%0d", i), wrHit, VECS[i].eWr);
      check($sformatf("R6 R7 rdInc v%0d", i), rdInc, VECS[i].eRdInc);
      check($sformatf("R6 R7 wrInc v%0d", i), wrInc, VECS[i].eWrInc);
      check($sformatf("R8 rdTotal v%0d", i), rdTotal, mRd);
      check($sformatf("R8 wrTotal v%0d", i), wrTotal, mWr);
    end
    // strobe is a single pulse (R3)
    @(negedge clk);
    check("R3 pulse ends rd", rdHit, 0);
    check("R3 pulse ends wr", wrHit, 0);

    // R2: write concurrent with handshake uses old setting
    writeCfg(32'h0000_0077);
    step(1, 32'h0000_0088, 1, 1, 16'h0077, 0, 0, 16'h0, 8'd0, 3'd0, 0, 0);
    check("R2 old setting in write cycle", rdHit, 1);
    step(0, 0, 1, 1, 16'h0088, 1, 1, 16'h0077, 8'd0, 3'd0, 0, 0);
    check("R2 new setting applies", rdHit, 1);
    check("R2 old id rejected", wrHit, 0);
    mRd = mRd + 2;
    check("R8 rdTotal after R2", rdTotal, mRd);

    // R9: clear with concurrent read strobe, write not strobed
    writeCfg(32'h0000_0042);
    step(0, 0, 1, 1, 16'h0042, 1, 1, 16'h0041, 8'd1, 3'd1, 1, 1);
    check("R9 rdTotal = inc", rdTotal, 4);
    check("R9 wrTotal cleared", wrTotal, 0);
    step(0, 0, 0, 0, 16'h0, 0, 0, 16'h0, 8'd0, 3'd0, 0, 1);
    check("R9 clear alone", rdTotal, 0);

    // R8 wrap: 4 + 0x8000 + 0x8000 wraps to 4
    step(0, 0, 1, 1, 16'h0042, 0, 0, 16'h0, 8'd1, 3'd1, 1, 0);
    writeCfg(32'hFFFF_0000);
    step(0, 0, 1, 1, 16'h1111, 0, 0, 16'h0, 8'd255, 3'd7, 1, 0);
    check("R8 half way", rdTotal, 16'h8004);
    step(0, 0, 1, 1, 16'h2222, 0, 0, 16'h0, 8'd255, 3'd7, 1, 0);
    check("R8 wrap", rdTotal, 16'h0004);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule